// File: doc/BRIEF.md
# Combined Program Counter and Status Word

This block is a single 32-bit register that packs several kinds of state into one word:

- the four condition flags;
- the two interrupt mask bits;
- a 24-bit word address for instruction fetch;
- the two-bit processor mode.

The word layout is fixed because other logic decodes it. Bits 31:28 hold N, Z, C and V. Bit 27 masks normal interrupts and bit 26 masks fast interrupts. Bits 25:2 hold the word address, and bits 1:0 hold the mode.

Each cycle the sequencer may request one or more of the following:

- a sequential step of the address;
- a branch that replaces the address only;
- a full-word load;
- a flag update from the ALU.

Write permission follows the current mode. In privileged modes a full load replaces every field. In user mode it reaches only the flags and the address, so unprivileged code cannot touch the masks or the mode.

The current mode and a privileged indication are driven out so that the register file can select its banked copies.

Top module: `pcsw_top`

## Requirements
- R1: After reset the word reads 0x0C000003: flags clear, both masks set (bit 27 = 1, bit 26 = 1), address zero, mode supervisor (bits 1:0 = 11).
- R2: A step request adds one to bits 25:2, wrapping from 0xFFFFFF to 0, and leaves all other bits unchanged.
- R3: A branch request replaces bits 25:2 with the branch address and leaves all other bits unchanged.
- R4: A full load while the mode is privileged (bits 1:0 not equal to 00; 01 fast interrupt, 10 interrupt, 11 supervisor) writes the whole loaded word, including a change of mode.
- R5: A full load while the mode is user (bits 1:0 = 00) writes bits 31:28 and 25:2 only; bits 27:26 and 1:0 keep their values.
- R6: A flag update replaces bits 31:28 only. An address step or branch requested in the same cycle still takes effect.
- R7: When requests coincide, full load wins over branch, and branch wins over step. A full load also overrides a flag update in the same cycle.
- R8: The mode output always equals bits 1:0 of the word. The privileged output is 1 exactly when the mode is not 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| inc_en | input | 1 | Step the address by one word |
| br_en | input | 1 | Load the address field from br_addr |
| br_addr | input | 24 | Branch target word address |
| ld_en | input | 1 | Full-word load, masked in user mode |
| ld_word | input | 32 | Word to load |
| flg_en | input | 1 | Update condition flags |
| flg_in | input | 4 | New flags, N Z C V from bit 3 down |
| word_o | output | 32 | Current register word |
| mode_o | output | 2 | Current mode |
| priv_o | output | 1 | Current mode is privileged |

## Verification
The assertions assume that every request input is settled and known at each rising edge. They also assume that ld_word may carry any mask and mode bits, including illegal attempts from user mode.

The stimulus changes inputs only at the falling edge. It visits every mode, including a switch into user mode, and then tries loads that would lift the masks or return to supervisor.

Coinciding requests are driven on purpose, so that the priority rules are exercised rather than assumed.

// File: rtl/pcsw_pkg.sv
package pcsw_pkg;
  localparam int FLAG_W = 4;
  localparam int MASK_W = 2;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_USER = 2'b00,
    MODE_FIQ  = 2'b01,
    MODE_IRQ  = 2'b10,
    MODE_SVC  = 2'b11
  } mode_e;

  function automatic logic is_priv(input logic [MODE_W-1:0] m);
    return m != MODE_USER;
  endfunction
endpackage

// File: rtl/pcsw_addr_path.sv
module pcsw_addr_path #(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic              inc_en,
  input  logic              br_en,
  input  logic [ADDR_W-1:0] br_addr,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic [ADDR_W-1:0] nxt_addr
);
  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  always_comb begin
    if (ld_en)       nxt_addr = ld_addr;
    else if (br_en)  nxt_addr = br_addr;
    else if (inc_en) nxt_addr = step_addr(cur_addr);
    else             nxt_addr = cur_addr;
  end
endmodule

// File: rtl/pcsw_field_merge.sv
module pcsw_field_merge
  import pcsw_pkg::*;
(
  input  logic [FLAG_W-1:0] cur_flags,
  input  logic [MASK_W-1:0] cur_masks,
  input  logic [MODE_W-1:0] cur_mode,
  input  logic              ld_en,
  input  logic [FLAG_W-1:0] ld_flags,
  input  logic [MASK_W-1:0] ld_masks,
  input  logic [MODE_W-1:0] ld_mode,
  input  logic              flg_en,
  input  logic [FLAG_W-1:0] flg_in,
  output logic              ctrl_we,
  output logic [FLAG_W-1:0] nxt_flags,
  output logic [MASK_W-1:0] nxt_masks,
  output logic [MODE_W-1:0] nxt_mode
);
  assign ctrl_we = ld_en && is_priv(cur_mode);

  always_comb begin
    if (ld_en)       nxt_flags = ld_flags;
    else if (flg_en) nxt_flags = flg_in;
    else             nxt_flags = cur_flags;
    nxt_masks = ctrl_we ? ld_masks : cur_masks;
    nxt_mode  = ctrl_we ? ld_mode  : cur_mode;
  end
endmodule

// File: rtl/pcsw_top.sv
module pcsw_top
  import pcsw_pkg::*;
#(
  parameter int ADDR_W = 24,
  localparam int WORD_W = FLAG_W + MASK_W + ADDR_W + MODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc_en,
  input  logic              br_en,
  input  logic [ADDR_W-1:0] br_addr,
  input  logic              ld_en,
  input  logic [WORD_W-1:0] ld_word,
  input  logic              flg_en,
  input  logic [FLAG_W-1:0] flg_in,
  output logic [WORD_W-1:0] word_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              priv_o
);
  localparam int MODE_LO = 0;
  localparam int ADDR_LO = MODE_LO + MODE_W;
  localparam int MASK_LO = ADDR_LO + ADDR_W;
  localparam int FLAG_LO = MASK_LO + MASK_W;

  logic [FLAG_W-1:0] flags_q, flags_d;
  logic [MASK_W-1:0] masks_q, masks_d;
  logic [ADDR_W-1:0] addr_q,  addr_d;
  logic [MODE_W-1:0] mode_q,  mode_d;
  logic              ctrl_we;

  pcsw_addr_path #(.ADDR_W(ADDR_W)) u_addr (
    .cur_addr (addr_q),
    .inc_en   (inc_en),
    .br_en    (br_en),
    .br_addr  (br_addr),
    .ld_en    (ld_en),
    .ld_addr  (ld_word[MASK_LO-1:ADDR_LO]),
    .nxt_addr (addr_d)
  );

  pcsw_field_merge u_merge (
    .cur_flags (flags_q),
    .cur_masks (masks_q),
    .cur_mode  (mode_q),
    .ld_en     (ld_en),
    .ld_flags  (ld_word[WORD_W-1:FLAG_LO]),
    .ld_masks  (ld_word[FLAG_LO-1:MASK_LO]),
    .ld_mode   (ld_word[ADDR_LO-1:MODE_LO]),
    .flg_en    (flg_en),
    .flg_in    (flg_in),
    .ctrl_we   (ctrl_we),
    .nxt_flags (flags_d),
    .nxt_masks (masks_d),
    .nxt_mode  (mode_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      masks_q <= '1;
      addr_q  <= '0;
      mode_q  <= MODE_SVC;
    end else begin
      flags_q <= flags_d;
      masks_q <= masks_d;
      addr_q  <= addr_d;
      mode_q  <= mode_d;
    end
  end

  assign word_o = {flags_q, masks_q, addr_q, mode_q};
  assign mode_o = mode_q;
  assign priv_o = is_priv(mode_q);

  assert_step_wraps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && !br_en && !ld_en) |=> (addr_q == $past(addr_q) + ADDR_W'(1)));

  assert_branch_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (br_en && !ld_en) |=> (addr_q == $past(br_addr)));

  assert_priv_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && priv_o) |=> (word_o == $past(ld_word)));

  assert_user_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MODE_USER) |=> ($stable(masks_q) && $stable(mode_o) && !$past(ctrl_we)));

  assert_flags_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!flg_en && !ld_en) |=> $stable(flags_q));
endmodule

// File: tb/pcsw_top_bench.sv
`timescale 1ns/1ps
module pcsw_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inc_en = 0, br_en = 0, ld_en = 0, flg_en = 0;
  logic [23:0] br_addr = '0;
  logic [31:0] ld_word = '0;
  logic [3:0]  flg_in = '0;
  logic [31:0] word_o;
  logic [1:0]  mode_o;
  logic        priv_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] model;

  typedef struct {
    logic [31:0] word;
    string       req;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  pcsw_top u_pcsw_top (
    .clk(clk), .rst_n(rst_n), .inc_en(inc_en), .br_en(br_en), .br_addr(br_addr),
    .ld_en(ld_en), .ld_word(ld_word), .flg_en(flg_en), .flg_in(flg_in),
    .word_o(word_o), .mode_o(mode_o), .priv_o(priv_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input bit i, input bit b, input logic [23:0] ba, input bit l,
                    input logic [31:0] lw, input bit f, input logic [3:0] fv, input string req);
    logic [31:0] n;
    exp_t e;
    @(negedge clk);
    inc_en = i; br_en = b; br_addr = ba; ld_en = l; ld_word = lw; flg_en = f; flg_in = fv;
    n = model;
    if (l) begin
      if (model[1:0] != 2'b00) n = lw;
      else n = {lw[31:28], model[27:26], lw[25:2], model[1:0]};
    end else begin
      if (b) n[25:2] = ba;
      else if (i) n[25:2] = model[25:2] + 24'd1;
      if (f) n[31:28] = fv;
    end
    model = n;
    e.word = n;
    e.req = req;
    sb.push_back(e);
  endtask

  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(word_o === e.word, e.req, word_o, e.word);
      check(mode_o === e.word[1:0], "R8 mode", {30'd0, mode_o}, {30'd0, e.word[1:0]});
      check(priv_o === (e.word[1:0] != 2'b00), "R8 priv", {31'd0, priv_o},
            {31'd0, e.word[1:0] != 2'b00});
    end
  end

  initial begin
    #(200000 * 4);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    model = 32'h0C00_0003;
    repeat (3) @(negedge clk);
    check(word_o === 32'h0C00_0003, "R1 reset", word_o, 32'h0C00_0003);
    rst_n = 1'b1;
    @(negedge clk);
    check(word_o === 32'h0C00_0003, "R1 hold", word_o, 32'h0C00_0003);
    // R2 sequential steps
    op(1, 0, 0, 0, 0, 0, 0, "R2 step");
    op(1, 0, 0, 0, 0, 0, 0, "R2 step");
    op(0, 0, 0, 0, 0, 0, 0, "R2 idle");
    // R4 privileged load sets address near wrap point
    op(0, 0, 0, 1, {4'hA, 2'b11, 24'hFFFFFF, 2'b11}, 0, 0, "R4 load svc");
    op(1, 0, 0, 0, 0, 0, 0, "R2 wrap");
    // R3 branch only replaces address
    op(0, 1, 24'h123456, 0, 0, 0, 0, "R3 branch");
    // R6 flags with step in same cycle
    op(1, 0, 0, 0, 0, 1, 4'h5, "R6 flags+step");
    op(0, 1, 24'h00ABCD, 0, 0, 1, 4'hC, "R6 flags+branch");
    // R7 priority cases
    op(1, 1, 24'h000777, 0, 0, 0, 0, "R7 branch over step");
    op(1, 1, 24'h000888, 1, {4'h3, 2'b10, 24'h004000, 2'b10}, 1, 4'hF, "R7 load over all");
    // R4 now in irq, load fiq, then user
    op(0, 0, 0, 1, {4'h9, 2'b01, 24'h00F000, 2'b01}, 0, 0, "R4 load fiq");
    op(0, 0, 0, 1, {4'h1, 2'b00, 24'h000100, 2'b00}, 0, 0, "R4 enter user");
    // R5 user cannot raise masks or mode
    op(0, 0, 0, 1, {4'hE, 2'b11, 24'h0AAAAA, 2'b11}, 0, 0, "R5 user load");
    op(0, 0, 0, 1, {4'h7, 2'b10, 24'h055555, 2'b01}, 1, 4'h2, "R5 user load+flg");
    op(0, 0, 0, 0, 0, 1, 4'h8, "R6 user flags");
    op(1, 0, 0, 0, 0, 0, 0, "R2 user step");
    op(0, 0, 0, 0, 0, 0, 0, "R5 idle");
    @(negedge clk);
    inc_en = 0; br_en = 0; ld_en = 0; flg_en = 0;
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule